// File: doc/BRIEF.md
# Zoned External Bus Cycle Sequencer

This block produces the chip-select, read-strobe and write-strobe timing for accesses on an external parallel memory bus. Each access is split into three consecutive phases: a lead phase with chip-select up and no strobe, an active phase with the direction strobe up, and a trail phase with chip-select still up and the strobe released. Each phase lasts a programmed number of interface clock cycles.

Each address zone has its own timing set. A set holds separate lead, active and trail counts for reads and for writes, a doubling bit that scales the counts, a ready-enable bit and a ready-mode bit. An internal master starts an access with a one-cycle request carrying the zone and the direction. The block selects the zone's timing, runs the three phases and returns a one-cycle done pulse. If the zone samples ready synchronously, a low external ready stretches the active phase.

The block does not check for illegal settings. It runs whatever counts are programmed.

Top module: `ext_bus_seq`

## Requirements
- R1: Every access runs lead, then active, then trail. `bus_cs` is high in all three phases. The direction strobe is high only in the active phase, and `bus_rd` and `bus_wr` are never high together.
- R2: A read (`req_wr`=0) uses the zone's read counts and raises only `bus_rd`. A write (`req_wr`=1) uses the write counts and raises only `bus_wr`.
- R3: The timing set used is the one of the zone given in `req_zone` at the start. Zone z's fields sit at bits [z*CNT_W +: CNT_W] of each count port and at bit z of each per-zone flag port.
- R4: With the zone's doubling bit at 0, lead lasts LEAD cycles, active lasts ACTIVE+WS+1 cycles and trail lasts TRAIL cycles.
- R5: With the zone's doubling bit at 1, lead lasts 2*LEAD cycles, active lasts 2*ACTIVE+WS+1 cycles and trail lasts 2*TRAIL cycles.
- R6: A lead or trail count of 0 skips that phase entirely. An active count of 0 still gives at least one active cycle.
- R7: When the zone has `cfg_rdy_en`=1 and `cfg_rdy_async`=0, `bus_rdy` is sampled at the end of the last programmed active cycle and of every added cycle. Each low sample adds one active cycle. The first high sample ends the active phase.
- R8: When the zone has `cfg_rdy_en`=0, or has `cfg_rdy_async`=1 (an unsupported mode, treated as ignoring ready), `bus_rdy` has no effect and WS is 0.
- R9: `bus_cs` rises in the cycle after the clock edge that accepts `req_start`. `req_done` is high for exactly one cycle, the first cycle after the last cycle of the access.
- R10: A start request that arrives while an access is running is ignored. The running access keeps its zone, direction and lengths, and no extra access follows it.
- R11: While reset is asserted, `bus_cs`, `bus_rd`, `bus_wr` and `req_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle start request, accepted only when idle |
| req_zone | input | ZW | Zone of the requested access |
| req_wr | input | 1 | Direction: 1 for write, 0 for read |
| cfg_rd_lead | input | NZONES*CNT_W | Per-zone read lead count |
| cfg_rd_act | input | NZONES*CNT_W | Per-zone read active count |
| cfg_rd_trail | input | NZONES*CNT_W | Per-zone read trail count |
| cfg_wr_lead | input | NZONES*CNT_W | Per-zone write lead count |
| cfg_wr_act | input | NZONES*CNT_W | Per-zone write active count |
| cfg_wr_trail | input | NZONES*CNT_W | Per-zone write trail count |
| cfg_dbl | input | NZONES | Per-zone doubling of phase counts |
| cfg_rdy_en | input | NZONES | Per-zone ready-sampling enable |
| cfg_rdy_async | input | NZONES | Per-zone ready mode: 0 synchronous, 1 asynchronous (treated as ignore) |
| bus_rdy | input | 1 | External ready |
| bus_cs | output | 1 | Chip select, high for the whole access |
| bus_rd | output | 1 | Read strobe, high in the active phase of a read |
| bus_wr | output | 1 | Write strobe, high in the active phase of a write |
| req_done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check on every cycle that the phases follow only legal transitions, that the two strobes never overlap and are never high without chip-select, and that done is a single-cycle pulse. They also check that a low ready sample on the final active count holds the active phase in sync mode, that the active phase always ends there when ready is ignored, and that the latched direction changes only from idle. The exact phase lengths for each zone, direction, doubling and count combination, the number of wait cycles, the start-to-select latency, and the rejection of a start while busy can only be shown by the bench. It measures every phase of every access at the ports and compares the counts with values computed from the formulas.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_ACT   = 2'd2,
    PH_TRAIL = 2'd3
  } ebs_phase_e;
endpackage

// File: rtl/ebs_cfg_sel.sv
// Selects the timing set of one zone and direction and scales it into phase lengths.
module ebs_cfg_sel #(
  parameter int NZONES = 4,
  parameter int CNT_W  = 4,
  parameter int ZW     = 2,
  parameter int LW     = CNT_W + 2
) (
  input  logic [ZW-1:0]           zone,
  input  logic                    is_wr,
  input  logic [NZONES*CNT_W-1:0] rd_lead,
  input  logic [NZONES*CNT_W-1:0] rd_act,
  input  logic [NZONES*CNT_W-1:0] rd_trail,
  input  logic [NZONES*CNT_W-1:0] wr_lead,
  input  logic [NZONES*CNT_W-1:0] wr_act,
  input  logic [NZONES*CNT_W-1:0] wr_trail,
  input  logic [NZONES-1:0]       dbl,
  input  logic [NZONES-1:0]       rdy_en,
  input  logic [NZONES-1:0]       rdy_async,
  output logic [LW-1:0]           lead_len,
  output logic [LW-1:0]           act_len,
  output logic [LW-1:0]           trail_len,
  output logic                    sync_rdy
);
  logic [CNT_W-1:0] lead_z  [NZONES];
  logic [CNT_W-1:0] act_z   [NZONES];
  logic [CNT_W-1:0] trail_z [NZONES];

  for (genvar g = 0; g < NZONES; g++) begin : g_zone
    assign lead_z[g]  = is_wr ? wr_lead[g*CNT_W +: CNT_W]  : rd_lead[g*CNT_W +: CNT_W];
    assign act_z[g]   = is_wr ? wr_act[g*CNT_W +: CNT_W]   : rd_act[g*CNT_W +: CNT_W];
    assign trail_z[g] = is_wr ? wr_trail[g*CNT_W +: CNT_W] : rd_trail[g*CNT_W +: CNT_W];
  end

  always_comb begin
    int unsigned zi;
    logic         dsel;
    zi   = (int'(zone) < NZONES) ? int'(zone) : 0;
    dsel = dbl[zi];
    lead_len  = dsel ? (LW'(lead_z[zi])  << 1) : LW'(lead_z[zi]);
    act_len   = (dsel ? (LW'(act_z[zi])  << 1) : LW'(act_z[zi])) + LW'(1);
    trail_len = dsel ? (LW'(trail_z[zi]) << 1) : LW'(trail_z[zi]);
    sync_rdy  = rdy_en[zi] & ~rdy_async[zi];
  end
endmodule

// File: rtl/ebs_phase_ctl.sv
// Phase sequencer: lead -> active (+ready waits) -> trail, with latched lengths.
module ebs_phase_ctl
  import ebs_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_in,
  input  logic [LW-1:0] lead_len,
  input  logic [LW-1:0] act_len,
  input  logic [LW-1:0] trail_len,
  input  logic          sync_rdy,
  input  logic          ext_rdy,
  output ebs_phase_e    phase_o,
  output logic          wr_o,
  output logic          done_o
);
  ebs_phase_e    phase_q, phase_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] act_q, act_d;
  logic [LW-1:0] trail_q, trail_d;
  logic          sync_q, sync_d;
  logic          wr_q, wr_d;
  logic          done_q, done_d;
  logic          en;

  assign en = start | done_q | (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    trail_d = trail_q;
    sync_d  = sync_q;
    wr_d    = wr_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          wr_d    = wr_in;
          act_d   = act_len;
          trail_d = trail_len;
          sync_d  = sync_rdy;
          if (lead_len != '0) begin
            phase_d = PH_LEAD;
            cnt_d   = lead_len - LW'(1);
          end else begin
            phase_d = PH_ACT;
            cnt_d   = act_len - LW'(1);
          end
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACT;
          cnt_d   = act_q - LW'(1);
        end else begin
          cnt_d = cnt_q - LW'(1);
        end
      end
      PH_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - LW'(1);
        end else if (!sync_q || ext_rdy) begin
          if (trail_q != '0) begin
            phase_d = PH_TRAIL;
            cnt_d   = trail_q - LW'(1);
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - LW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      trail_q <= '0;
      sync_q  <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      trail_q <= trail_d;
      sync_q  <= sync_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign wr_o    = wr_q;
  assign done_o  = done_q;

  // R1: legal phase order
  p_lead_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_LEAD |=> (phase_q == PH_LEAD || phase_q == PH_ACT));
  p_act_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_ACT |=> phase_q != PH_LEAD);
  p_trail_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_TRAIL |=> (phase_q == PH_TRAIL || phase_q == PH_IDLE));
  // R7: low ready on the final active count holds the active phase
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACT && cnt_q == '0 && sync_q && !ext_rdy) |=> phase_q == PH_ACT);
  // R8: without ready sampling the active phase ends on its final count
  p_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACT && cnt_q == '0 && !sync_q) |=> phase_q != PH_ACT);
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: the latched direction only changes from idle
  p_dir_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_IDLE |=> $stable(wr_q));
endmodule

// File: rtl/ext_bus_seq.sv
// Top level: zone timing selection, phase sequencing and strobe decode.
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int NZONES = 4,
  parameter int CNT_W  = 4,
  localparam int ZW    = (NZONES > 1) ? $clog2(NZONES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_start,
  input  logic [ZW-1:0]           req_zone,
  input  logic                    req_wr,
  input  logic [NZONES*CNT_W-1:0] cfg_rd_lead,
  input  logic [NZONES*CNT_W-1:0] cfg_rd_act,
  input  logic [NZONES*CNT_W-1:0] cfg_rd_trail,
  input  logic [NZONES*CNT_W-1:0] cfg_wr_lead,
  input  logic [NZONES*CNT_W-1:0] cfg_wr_act,
  input  logic [NZONES*CNT_W-1:0] cfg_wr_trail,
  input  logic [NZONES-1:0]       cfg_dbl,
  input  logic [NZONES-1:0]       cfg_rdy_en,
  input  logic [NZONES-1:0]       cfg_rdy_async,
  input  logic                    bus_rdy,
  output logic                    bus_cs,
  output logic                    bus_rd,
  output logic                    bus_wr,
  output logic                    req_done
);
  localparam int LW = CNT_W + 2;

  logic [LW-1:0] lead_len, act_len, trail_len;
  logic          sync_rdy;
  ebs_phase_e    phase;
  logic          wr_lat;

  ebs_cfg_sel #(.NZONES(NZONES), .CNT_W(CNT_W), .ZW(ZW), .LW(LW)) u_sel (
    .zone      (req_zone),
    .is_wr     (req_wr),
    .rd_lead   (cfg_rd_lead),
    .rd_act    (cfg_rd_act),
    .rd_trail  (cfg_rd_trail),
    .wr_lead   (cfg_wr_lead),
    .wr_act    (cfg_wr_act),
    .wr_trail  (cfg_wr_trail),
    .dbl       (cfg_dbl),
    .rdy_en    (cfg_rdy_en),
    .rdy_async (cfg_rdy_async),
    .lead_len  (lead_len),
    .act_len   (act_len),
    .trail_len (trail_len),
    .sync_rdy  (sync_rdy)
  );

  ebs_phase_ctl #(.LW(LW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (req_start),
    .wr_in     (req_wr),
    .lead_len  (lead_len),
    .act_len   (act_len),
    .trail_len (trail_len),
    .sync_rdy  (sync_rdy),
    .ext_rdy   (bus_rdy),
    .phase_o   (phase),
    .wr_o      (wr_lat),
    .done_o    (req_done)
  );

  assign bus_cs = (phase != PH_IDLE);
  assign bus_rd = (phase == PH_ACT) & ~wr_lat;
  assign bus_wr = (phase == PH_ACT) &  wr_lat;

  // R1: strobes are exclusive and lie inside chip select
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_strobe_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_cs);
  // R9: done follows the final access cycle and never overlaps chip select
  p_done_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !bus_cs);
endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  localparam int NZ = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_start, req_wr, bus_rdy;
  logic [1:0] req_zone;
  logic [NZ*CW-1:0] f_rl, f_ra, f_rt, f_wl, f_wa, f_wt;
  logic [NZ-1:0] cfg_dbl, cfg_rdy_en, cfg_rdy_async;
  logic bus_cs, bus_rd, bus_wr, req_done;

  int rl [NZ], ra [NZ], rt [NZ], wl [NZ], wa [NZ], wt [NZ];
  int total = 0;
  int bad = 0;
  int rdy_target = 1000;

  always #2 clk = ~clk;

  always_comb begin
    for (int z = 0; z < NZ; z++) begin
      f_rl[z*CW +: CW] = CW'(rl[z]);
      f_ra[z*CW +: CW] = CW'(ra[z]);
      f_rt[z*CW +: CW] = CW'(rt[z]);
      f_wl[z*CW +: CW] = CW'(wl[z]);
      f_wa[z*CW +: CW] = CW'(wa[z]);
      f_wt[z*CW +: CW] = CW'(wt[z]);
    end
  end

  ext_bus_seq #(.NZONES(NZ), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_zone(req_zone),
    .req_wr(req_wr), .cfg_rd_lead(f_rl), .cfg_rd_act(f_ra), .cfg_rd_trail(f_rt),
    .cfg_wr_lead(f_wl), .cfg_wr_act(f_wa), .cfg_wr_trail(f_wt),
    .cfg_dbl(cfg_dbl), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_async(cfg_rdy_async),
    .bus_rdy(bus_rdy), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .req_done(req_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fill every zone with background values that differ from the target zone.
  task automatic background(input bit d_other);
    for (int z = 0; z < NZ; z++) begin
      rl[z] = 3; ra[z] = 3; rt[z] = 3;
      wl[z] = 3; wa[z] = 3; wt[z] = 3;
      cfg_dbl[z] = d_other;
      cfg_rdy_en[z] = 1'b0;
      cfg_rdy_async[z] = 1'b0;
    end
  endtask

  // Run one access and measure its phases at the ports.
  task automatic run_access(input int z, input bit w, input int el, input int ea,
                            input int et, input bit poke, input string tag);
    int nl = 0, na = 0, nt = 0, dir_bad = 0, order_bad = 0, cyc = 0;
    bit cs_first;
    @(negedge clk);
    req_zone = 2'(z); req_wr = w; req_start = 1'b1; bus_rdy = 1'b0;
    @(negedge clk);
    req_start = 1'b0;
    cs_first = bus_cs;
    chk(cs_first == 1'b1, {"R9 cs latency ", tag}, int'(cs_first), 1);
    while (bus_cs && cyc < 200) begin
      if (req_done) order_bad++;
      if (bus_rd || bus_wr) begin
        if (nt > 0) order_bad++;
        na++;
        if (w ? !(bus_wr && !bus_rd) : !(bus_rd && !bus_wr)) dir_bad++;
      end else if (na == 0) begin
        nl++;
      end else begin
        nt++;
      end
      bus_rdy = (na >= rdy_target);
      if (poke && cyc == 0) begin
        req_start = 1'b1; req_zone = 2'(z ^ 1); req_wr = ~w;
      end else begin
        req_start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    req_start = 1'b0;
    bus_rdy = 1'b0;
    chk(nl == el, {"R4/R5/R6 lead ", tag}, nl, el);
    chk(na == ea, {"R4/R5/R7 active ", tag}, na, ea);
    chk(nt == et, {"R4/R5/R6 trail ", tag}, nt, et);
    chk(dir_bad == 0 && order_bad == 0, {"R1/R2 strobe order ", tag}, dir_bad + order_bad, 0);
    chk(req_done == 1'b1, {"R9 done after access ", tag}, int'(req_done), 1);
    @(negedge clk);
    chk(req_done == 1'b0 && bus_cs == 1'b0, {"R9/R10 done width, no extra access ", tag},
        int'(req_done) + int'(bus_cs), 0);
  endtask

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_wr = 1'b0; req_zone = '0; bus_rdy = 1'b0;
    background(1'b0);
    repeat (3) @(negedge clk);
    // R11: outputs low in reset
    chk({bus_cs, bus_rd, bus_wr, req_done} == 4'b0, "R11 reset outputs",
        int'({bus_cs, bus_rd, bus_wr, req_done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Sweep: every zone, direction, doubling and count, ready ignored and held low (R3..R6, R8)
    rdy_target = 1000;
    for (int z = 0; z < NZ; z++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          for (int l = 0; l < 4; l++)
            for (int a = 0; a < 4; a++)
              for (int t = 0; t < 4; t++) begin
                background(~d[0]);
                cfg_dbl[z] = d[0];
                if (w == 1) begin wl[z] = l; wa[z] = a; wt[z] = t; end
                else        begin rl[z] = l; ra[z] = a; rt[z] = t; end
                run_access(z, w[0], d ? 2*l : l, (d ? 2*a : a) + 1, d ? 2*t : t, 1'b0,
                           $sformatf("R3 z%0d w%0d d%0d l%0d a%0d t%0d", z, w, d, l, a, t));
              end

    // Synchronous ready: wait states added per low sample (R7)
    for (int z = 0; z < NZ; z++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 4; a++)
            for (int ws = 0; ws < 4; ws++) begin
              int base;
              background(1'b0);
              cfg_dbl[z] = d[0]; cfg_rdy_en[z] = 1'b1; cfg_rdy_async[z] = 1'b0;
              if (w == 1) begin wl[z] = 1; wa[z] = a; wt[z] = 1; end
              else        begin rl[z] = 1; ra[z] = a; rt[z] = 1; end
              base = (d ? 2*a : a) + 1;
              rdy_target = base + ws;
              run_access(z, w[0], d ? 2 : 1, base + ws, d ? 2 : 1, 1'b0,
                         $sformatf("R7 z%0d w%0d d%0d a%0d ws%0d", z, w, d, a, ws));
            end

    // Ready low but zone in asynchronous mode or disabled: no waits (R8)
    rdy_target = 1000;
    for (int z = 0; z < NZ; z++)
      for (int m = 0; m < 2; m++) begin
        background(1'b0);
        cfg_rdy_en[z] = (m == 1);
        cfg_rdy_async[z] = 1'b1;
        rl[z] = 1; ra[z] = 2; rt[z] = 2;
        run_access(z, 1'b0, 1, 3, 2, 1'b0, $sformatf("R8 z%0d en%0d", z, m));
      end

    // Start during a running access is ignored (R10)
    for (int z = 0; z < NZ; z++) begin
      background(1'b1);
      cfg_dbl[z] = 1'b0;
      wl[z] = 1; wa[z] = 1; wt[z] = 2;
      run_access(z, 1'b1, 1, 2, 2, 1'b1, $sformatf("R10 z%0d", z));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule